// File: doc/BRIEF.md
# Line-Precision Data Cache

This block is a small direct-mapped, write-back, write-allocate data cache in which every line carries one precision flag. The flag marks whether the line's contents may be held approximately (1) or must be held exactly (0). A request brings a word address, a read/write select, write data and the request's own precision flag. The cache serves hits from its arrays. On a miss it evicts the victim line, writing it back first if it is dirty, and then fills the line word by word over a simple backing-memory handshake.

The precision flag of a line changes only on a fill or a write hit. Both copy the precision of the request. A read hit of either precision is served from a line of either precision and leaves the flag as it was. Tags, valid bits, dirty bits and the miss registers do not depend on precision and are always exact. A debug port reports the valid bit and precision flag of any line picked by index.

The request side is valid/ready. A request is taken on a cycle where `req_valid` and `req_ready` are both high. `req_ready` is low from the cycle after a miss is accepted until the miss has been answered, so only one miss is ever outstanding. The response side has no back-pressure: `rsp_valid` is a one-cycle pulse that the requester must accept. The memory request is valid/ready. While `mem_req_valid` is high and `mem_req_ready` is low, the address, direction and write data stay unchanged. Memory read data comes back on `mem_rsp_valid` at any later cycle.

Top module: `pc_cache`

## Requirements
- R1: After reset, every line reads back invalid and exact on the debug port, `req_ready` is high and `rsp_valid` is low.
- R2: A read hit is answered with `rsp_valid` on the cycle after acceptance, carrying the last value written to that word address.
- R3: A write hit stores the word, sets the line's precision flag to the write's `req_approx`, and is acknowledged with `rsp_valid` on the cycle after acceptance.
- R4: A read hit never changes the line's precision flag, for all four combinations of line precision and request precision.
- R5: A miss fills all four words of the line from memory, sets the line valid with the missing request's precision, and then serves the request with the correct data.
- R6: When a dirty line is evicted, all four of its words are written back to memory before the fill. The new line's precision comes only from the missing request and never from the victim.
- R7: While a miss is in progress, `req_ready` is low, and it is high again on the cycle the response is given.
- R8: A memory request that is not yet accepted keeps its valid, direction, address and write data unchanged on the next cycle.
- R9: Address mapping: word address bits [1:0] select the word in the line, bits [5:2] select one of 16 lines, and the remaining upper bits form the tag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Cache can accept a request |
| req_addr | input | AW (12) | Word address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | DW (32) | Write data |
| req_approx | input | 1 | Request precision, 1 = approximate |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_rdata | output | DW (32) | Read data (zero for writes) |
| mem_req_valid | output | 1 | Memory request present |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_write | output | 1 | 1 = write-back word, 0 = fill read |
| mem_req_addr | output | AW (12) | Memory word address |
| mem_req_wdata | output | DW (32) | Write-back data |
| mem_rsp_valid | input | 1 | Fill read data present |
| mem_rsp_data | input | DW (32) | Fill read data |
| dbg_idx | input | IDXW (4) | Line selected for the debug port |
| dbg_valid | output | 1 | Valid bit of the selected line |
| dbg_approx | output | 1 | Precision flag of the selected line |

## Verification
The bench sweeps every line index with all four pairings of line precision and read precision. It then runs a long pseudo-random mix confined to four tags per index, so conflict evictions of both clean and dirty lines happen often. If a design let a read hit copy the request's precision into the line, its debug flag would flip on an exact read of an approximate line. If a design kept the victim's flag across an eviction, the new line would report the wrong precision. A lost or reordered write-back shows up as stale data when the evicted address is read again. A design that accepted requests during a fill would show `req_ready` high while a miss is pending. The memory model keeps `mem_req_ready` low on alternate cycles to test that requests stay stable under back-pressure.

// File: rtl/pcc_pkg.sv
package pcc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WB,
    ST_FILL_REQ,
    ST_FILL_WAIT,
    ST_DONE
  } pcc_state_e;
endpackage

// File: rtl/pcc_tag_store.sv
module pcc_tag_store #(
  parameter int LINES = 16,
  parameter int TAGW  = 6,
  localparam int IDXW = $clog2(LINES)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [IDXW-1:0] lk_idx,
  output logic            lk_valid,
  output logic            lk_dirty,
  output logic [TAGW-1:0] lk_tag,
  input  logic            fill_en,
  input  logic [IDXW-1:0] fill_idx,
  input  logic [TAGW-1:0] fill_tag,
  input  logic            fill_approx,
  input  logic            wr_en,
  input  logic [IDXW-1:0] wr_idx,
  input  logic            wr_approx,
  input  logic [IDXW-1:0] dbg_idx,
  output logic            dbg_valid,
  output logic            dbg_approx
);
  logic            vld_q [LINES];
  logic            drt_q [LINES];
  logic            apx_q [LINES];
  logic [TAGW-1:0] tag_q [LINES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < LINES; i++) begin
        vld_q[i] <= 1'b0;
        drt_q[i] <= 1'b0;
        apx_q[i] <= 1'b0;
        tag_q[i] <= '0;
      end
    end else begin
      for (int i = 0; i < LINES; i++) begin
        if (fill_en && fill_idx == IDXW'(i)) begin
          vld_q[i] <= 1'b1;
          drt_q[i] <= 1'b0;
          apx_q[i] <= fill_approx;
          tag_q[i] <= fill_tag;
        end else if (wr_en && wr_idx == IDXW'(i)) begin
          drt_q[i] <= 1'b1;
          apx_q[i] <= wr_approx;
        end
      end
    end
  end

  assign lk_valid   = vld_q[lk_idx];
  assign lk_dirty   = drt_q[lk_idx];
  assign lk_tag     = tag_q[lk_idx];
  assign dbg_valid  = vld_q[dbg_idx];
  assign dbg_approx = apx_q[dbg_idx];
endmodule

// File: rtl/pcc_data_store.sv
module pcc_data_store #(
  parameter int ENTRIES = 64,
  parameter int DW      = 32,
  localparam int EW     = $clog2(ENTRIES)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [EW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [EW-1:0] raddr_a,
  output logic [DW-1:0] rdata_a,
  input  logic [EW-1:0] raddr_b,
  output logic [DW-1:0] rdata_b
);
  logic [DW-1:0] mem_q [ENTRIES];

  always_ff @(posedge clk) begin
    if (we) mem_q[waddr] <= wdata;
  end

  assign rdata_a = mem_q[raddr_a];
  assign rdata_b = mem_q[raddr_b];
endmodule

// File: rtl/pcc_ctrl.sv
module pcc_ctrl
  import pcc_pkg::*;
#(
  parameter int AW   = 12,
  parameter int DW   = 32,
  parameter int IDXW = 4,
  parameter int OFFW = 2,
  localparam int TAGW = AW - IDXW - OFFW,
  localparam int EW   = IDXW + OFFW
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic [AW-1:0]   req_addr,
  input  logic            req_write,
  input  logic [DW-1:0]   req_wdata,
  input  logic            req_approx,
  output logic            rsp_valid,
  output logic [DW-1:0]   rsp_rdata,
  output logic            mem_req_valid,
  input  logic            mem_req_ready,
  output logic            mem_req_write,
  output logic [AW-1:0]   mem_req_addr,
  output logic [DW-1:0]   mem_req_wdata,
  input  logic            mem_rsp_valid,
  input  logic [DW-1:0]   mem_rsp_data,
  output logic [IDXW-1:0] lk_idx,
  input  logic            lk_valid,
  input  logic            lk_dirty,
  input  logic [TAGW-1:0] lk_tag,
  output logic            hit,
  output logic            fill_en,
  output logic [TAGW-1:0] fill_tag,
  output logic            fill_approx,
  output logic            wr_en,
  output logic            wr_approx,
  output logic            dw_en,
  output logic [EW-1:0]   dw_addr,
  output logic [DW-1:0]   dw_data,
  output logic [EW-1:0]   rd_a_addr,
  input  logic [DW-1:0]   rd_a,
  output logic [EW-1:0]   rd_b_addr,
  input  logic [DW-1:0]   rd_b
);
  pcc_state_e      st_q;
  logic [AW-1:0]   m_addr_q;
  logic            m_write_q, m_approx_q;
  logic [DW-1:0]   m_wdata_q;
  logic [OFFW-1:0] beat_q;

  logic [AW-1:0]   c_addr;
  logic            c_write, c_approx;
  logic [DW-1:0]   c_wdata;
  logic [IDXW-1:0] c_idx;
  logic [OFFW-1:0] c_off;
  logic [TAGW-1:0] c_tag;
  logic            accept, serve, fill_beat;

  // In idle the live request is looked up; otherwise the captured miss.
  always_comb begin
    if (st_q == ST_IDLE) begin
      c_addr = req_addr;  c_write = req_write;
      c_wdata = req_wdata; c_approx = req_approx;
    end else begin
      c_addr = m_addr_q;  c_write = m_write_q;
      c_wdata = m_wdata_q; c_approx = m_approx_q;
    end
  end

  assign c_idx  = c_addr[OFFW +: IDXW];
  assign c_off  = c_addr[OFFW-1:0];
  assign c_tag  = c_addr[AW-1 -: TAGW];
  assign lk_idx = c_idx;
  assign hit    = lk_valid && (lk_tag == c_tag);

  assign accept    = (st_q == ST_IDLE) && req_valid;
  assign serve     = (accept && hit) || (st_q == ST_DONE);
  assign fill_beat = (st_q == ST_FILL_WAIT) && mem_rsp_valid;

  assign req_ready     = (st_q == ST_IDLE);
  assign mem_req_valid = (st_q == ST_WB) || (st_q == ST_FILL_REQ);
  assign mem_req_write = (st_q == ST_WB);
  assign mem_req_addr  = (st_q == ST_WB) ? {lk_tag, c_idx, beat_q} : {c_tag, c_idx, beat_q};
  assign mem_req_wdata = rd_b;
  assign rd_b_addr     = {c_idx, beat_q};
  assign rd_a_addr     = {c_idx, c_off};

  assign dw_en   = fill_beat || (serve && c_write);
  assign dw_addr = fill_beat ? {c_idx, beat_q} : {c_idx, c_off};
  assign dw_data = fill_beat ? mem_rsp_data : c_wdata;

  assign wr_en       = serve && c_write;
  assign wr_approx   = c_approx;
  assign fill_en     = fill_beat && (&beat_q);
  assign fill_tag    = c_tag;
  assign fill_approx = c_approx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= ST_IDLE;
      beat_q     <= '0;
      m_addr_q   <= '0;
      m_write_q  <= 1'b0;
      m_wdata_q  <= '0;
      m_approx_q <= 1'b0;
      rsp_valid  <= 1'b0;
      rsp_rdata  <= '0;
    end else begin
      rsp_valid <= serve;
      rsp_rdata <= (serve && !c_write) ? rd_a : '0;
      unique case (st_q)
        ST_IDLE: if (accept && !hit) begin
          m_addr_q   <= req_addr;
          m_write_q  <= req_write;
          m_wdata_q  <= req_wdata;
          m_approx_q <= req_approx;
          beat_q     <= '0;
          st_q       <= (lk_valid && lk_dirty) ? ST_WB : ST_FILL_REQ;
        end
        ST_WB: if (mem_req_ready) begin
          beat_q <= beat_q + 1'b1;
          if (&beat_q) st_q <= ST_FILL_REQ;
        end
        ST_FILL_REQ: if (mem_req_ready) st_q <= ST_FILL_WAIT;
        ST_FILL_WAIT: if (mem_rsp_valid) begin
          beat_q <= beat_q + 1'b1;
          st_q   <= (&beat_q) ? ST_DONE : ST_FILL_REQ;
        end
        ST_DONE: st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pc_cache.sv
module pc_cache #(
  parameter int AW    = 12,
  parameter int DW    = 32,
  parameter int LINES = 16,
  parameter int WORDS = 4,
  localparam int IDXW = $clog2(LINES),
  localparam int OFFW = $clog2(WORDS),
  localparam int TAGW = AW - IDXW - OFFW,
  localparam int EW   = IDXW + OFFW
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic [AW-1:0]   req_addr,
  input  logic            req_write,
  input  logic [DW-1:0]   req_wdata,
  input  logic            req_approx,
  output logic            rsp_valid,
  output logic [DW-1:0]   rsp_rdata,
  output logic            mem_req_valid,
  input  logic            mem_req_ready,
  output logic            mem_req_write,
  output logic [AW-1:0]   mem_req_addr,
  output logic [DW-1:0]   mem_req_wdata,
  input  logic            mem_rsp_valid,
  input  logic [DW-1:0]   mem_rsp_data,
  input  logic [IDXW-1:0] dbg_idx,
  output logic            dbg_valid,
  output logic            dbg_approx
);
  logic [IDXW-1:0] lk_idx;
  logic            lk_valid, lk_dirty, hit_w;
  logic [TAGW-1:0] lk_tag, fill_tag;
  logic            fill_en, fill_approx, wr_en, wr_approx, dw_en;
  logic [EW-1:0]   dw_addr, rd_a_addr, rd_b_addr;
  logic [DW-1:0]   dw_data, rd_a, rd_b;

  pcc_ctrl #(.AW(AW), .DW(DW), .IDXW(IDXW), .OFFW(OFFW)) u_ctrl (
    .clk, .rst_n, .req_valid, .req_ready, .req_addr, .req_write, .req_wdata,
    .req_approx, .rsp_valid, .rsp_rdata, .mem_req_valid, .mem_req_ready,
    .mem_req_write, .mem_req_addr, .mem_req_wdata, .mem_rsp_valid, .mem_rsp_data,
    .lk_idx, .lk_valid, .lk_dirty, .lk_tag, .hit(hit_w), .fill_en, .fill_tag,
    .fill_approx, .wr_en, .wr_approx, .dw_en, .dw_addr, .dw_data,
    .rd_a_addr, .rd_a, .rd_b_addr, .rd_b
  );

  pcc_tag_store #(.LINES(LINES), .TAGW(TAGW)) u_tags (
    .clk, .rst_n, .lk_idx, .lk_valid, .lk_dirty, .lk_tag,
    .fill_en, .fill_idx(lk_idx), .fill_tag, .fill_approx,
    .wr_en, .wr_idx(lk_idx), .wr_approx, .dbg_idx, .dbg_valid, .dbg_approx
  );

  pcc_data_store #(.ENTRIES(LINES * WORDS), .DW(DW)) u_data (
    .clk, .we(dw_en), .waddr(dw_addr), .wdata(dw_data),
    .raddr_a(rd_a_addr), .rdata_a(rd_a), .raddr_b(rd_b_addr), .rdata_b(rd_b)
  );
endmodule

// File: rtl/pcc_chk.sv
module pcc_chk #(
  parameter int AW   = 12,
  parameter int DW   = 32,
  parameter int IDXW = 4,
  parameter int OFFW = 2
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_valid,
  input logic            req_ready,
  input logic [AW-1:0]   req_addr,
  input logic            req_write,
  input logic            req_approx,
  input logic            hit,
  input logic [IDXW-1:0] dbg_idx,
  input logic            dbg_approx,
  input logic            mem_req_valid,
  input logic            mem_req_ready,
  input logic            mem_req_write,
  input logic [AW-1:0]   mem_req_addr,
  input logic [DW-1:0]   mem_req_wdata
);
  logic acc_on_dbg;
  assign acc_on_dbg = req_valid && req_ready && hit && (req_addr[OFFW +: IDXW] == dbg_idx);

  // R4
  read_hit_keeps_precision_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_on_dbg && !req_write |=> (!$stable(dbg_idx) || $stable(dbg_approx)));

  // R3
  write_hit_sets_precision_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_on_dbg && req_write |=> (!$stable(dbg_idx) || dbg_approx == $past(req_approx)));

  // R7
  busy_while_memory_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> !req_ready);

  // R8
  mem_req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=>
      mem_req_valid && $stable(mem_req_write) && $stable(mem_req_addr) && $stable(mem_req_wdata));
endmodule

bind pc_cache pcc_chk #(.AW(AW), .DW(DW), .IDXW(IDXW), .OFFW(OFFW)) chk_i (
  .clk, .rst_n, .req_valid, .req_ready, .req_addr, .req_write, .req_approx,
  .hit(hit_w), .dbg_idx, .dbg_approx, .mem_req_valid, .mem_req_ready,
  .mem_req_write, .mem_req_addr, .mem_req_wdata
);

// File: tb/pc_cache_tb_top.sv
module pc_cache_tb_top;
  localparam int AW = 12;
  localparam int DW = 32;
  localparam int NW = 1 << AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic          req_valid = 1'b0, req_write = 1'b0, req_approx = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic          req_ready, rsp_valid;
  logic [DW-1:0] rsp_rdata;
  logic          mem_req_valid, mem_req_write;
  logic          mem_req_ready = 1'b0;
  logic [AW-1:0] mem_req_addr;
  logic [DW-1:0] mem_req_wdata;
  logic          mem_rsp_valid = 1'b0;
  logic [DW-1:0] mem_rsp_data = '0;
  logic [3:0]    dbg_idx = '0;
  logic          dbg_valid, dbg_approx;

  pc_cache dut_i (
    .clk, .rst_n, .req_valid, .req_ready, .req_addr, .req_write, .req_wdata,
    .req_approx, .rsp_valid, .rsp_rdata, .mem_req_valid, .mem_req_ready,
    .mem_req_write, .mem_req_addr, .mem_req_wdata, .mem_rsp_valid, .mem_rsp_data,
    .dbg_idx, .dbg_valid, .dbg_approx
  );

  // Backing memory: ready on alternate cycles, read data one cycle after accept.
  logic [DW-1:0] bmem [NW];
  logic          pend = 1'b0;
  logic [AW-1:0] paddr = '0;
  function automatic logic [DW-1:0] seed_word(input int a);
    return (a * 32'h0100_0193) ^ 32'h5a5a_0000;
  endfunction
  initial for (int i = 0; i < NW; i++) bmem[i] = seed_word(i);

  always @(posedge clk) begin
    mem_req_ready <= ~mem_req_ready;
    pend <= 1'b0;
    if (mem_req_valid && mem_req_ready) begin
      if (mem_req_write) bmem[mem_req_addr] <= mem_req_wdata;
      else begin pend <= 1'b1; paddr <= mem_req_addr; end
    end
    mem_rsp_valid <= pend;
    mem_rsp_data  <= bmem[paddr];
  end

  // Golden state from the requirements.
  logic [DW-1:0] gmem [NW];
  logic          gv [16];
  logic          ga [16];
  logic [5:0]    gt [16];
  int errors = 0, checks = 0, cycles = 0;

  task automatic check(input bit ok, input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_op(input logic [AW-1:0] a, input bit wr, input logic [DW-1:0] wd, input bit ap);
    logic [3:0] idx;
    bit exp_hit, busy_ok, exp_ap;
    int cyc;
    idx = a[5:2];  // R9 mapping
    exp_hit = gv[idx] && gt[idx] == a[11:6];
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_write = wr; req_wdata = wd; req_approx = ap;
    dbg_idx = idx;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    cyc = 1; busy_ok = 1'b1;
    while (!rsp_valid) begin
      if (req_ready) busy_ok = 1'b0;
      @(negedge clk);
      cyc++;
    end
    if (exp_hit) check(cyc == 1, wr ? "R3 hit latency" : "R2 hit latency", cyc, 1);
    else check(cyc > 1 && busy_ok, "R7 ready low during miss", {31'd0, busy_ok}, 1);
    check(req_ready, "R7 ready back at response", req_ready, 1);
    if (!wr) check(rsp_rdata == gmem[a], exp_hit ? "R2 read data" : "R5/R6 miss data", rsp_rdata, gmem[a]);
    else gmem[a] = wd;
    exp_ap = (!exp_hit || wr) ? ap : ga[idx];
    check(dbg_valid && dbg_approx == exp_ap,
          !exp_hit ? "R5/R6 fill precision" : (wr ? "R3 write precision" : "R4 read keeps precision"),
          {30'd0, dbg_valid, dbg_approx}, {30'd0, 1'b1, exp_ap});
    gv[idx] = 1'b1; gt[idx] = a[11:6]; ga[idx] = exp_ap;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles >= 190000) begin
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=<190000", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    logic [15:0] lf;
    for (int i = 0; i < NW; i++) gmem[i] = seed_word(i);
    for (int i = 0; i < 16; i++) begin gv[i] = 1'b0; ga[i] = 1'b0; gt[i] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state of every line
    check(req_ready && !rsp_valid, "R1 idle handshake", {req_ready, rsp_valid}, 2'b10);
    for (int i = 0; i < 16; i++) begin
      dbg_idx = 4'(i);
      #1;
      check(!dbg_valid && !dbg_approx, "R1 line invalid and exact", {dbg_valid, dbg_approx}, 0);
    end
    // R6: dirty approximate victim, evicted by an exact read
    run_op(12'h00C, 1'b1, 32'hCAFE_0001, 1'b1);
    run_op(12'h04C, 1'b0, '0, 1'b0);
    check(dbg_approx == 1'b0, "R6 victim precision dropped", dbg_approx, 0);
    run_op(12'h00C, 1'b0, '0, 1'b1);
    // R4: every line, every pairing of line and read precision
    for (int i = 0; i < 16; i++) begin
      for (int p = 0; p < 2; p++) begin
        for (int q = 0; q < 2; q++) begin
          logic [AW-1:0] a;
          a = {6'(p + 2 * q), 4'(i), 2'(i + q)};
          run_op(a, 1'b1, {16'(i), 8'(p), 8'(q)}, p[0]);
          run_op(a, 1'b0, '0, q[0]);
          run_op({a[11:2], ~a[1:0]}, 1'b0, '0, ~q[0]);
        end
      end
    end
    // Mixed sweep over four tags per index, many evictions.
    lf = 16'hACE1;
    for (int n = 0; n < 800; n++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      run_op({4'd0, lf[1:0], lf[5:2], lf[7:6]}, lf[8], {lf, lf ^ 16'hA5C3}, lf[9]);
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule